// File: doc/BRIEF.md
# Link Integrity Monitor

This block decides whether a 100 Mb/s twisted-pair link is usable. It watches a data-valid flag from the receive signal processor. The flag must stay high for a programmable settling time before the link is considered ready. After that, the block either waits for a go-ahead from auto-negotiation or, when auto-negotiation is switched off, declares the link up without waiting. If the data-valid flag falls at any point, the link is dropped in the same cycle and the settling time must be served again from the start.

The reported link status and the LED drive share one source, chosen by the speed mode. At 100 Mb/s it is the state machine's own link. At 10 Mb/s it is the link flag from the 10BASE-T receiver, sampled once into a register. The transmit/receive enable is asserted only while the machine is in its up state and data-valid is still high. In 10 Mb/s mode this enable continues to follow the state machine.

Top module: `link_integrity_mon`

## Requirements
- R1: With `data_valid_i` held high from Down, the 100 Mb/s link cannot rise before `data_valid_i` has been sampled high on SETTLE_CYCLES+1 consecutive rising clock edges.
- R2: With `an_enable_i`=1, the machine waits in the ready state after settling. The link rises at the first rising edge after readiness at which `an_done_i` is sampled high. It stays low for as long as `an_done_i` is low.
- R3: With `an_enable_i`=0, the link rises right after the (SETTLE_CYCLES+1)th consecutive edge at which `data_valid_i` is sampled high, whatever the value of `an_done_i`.
- R4: While `data_valid_i` is low, `trx_enable_o` is low in the same cycle, with no wait for a clock edge. The machine then returns to Down, so the full settling time must be served again before the link comes back.
- R5: If `data_valid_i` falls during the settling wait, the count restarts from zero. Reaching the link again takes a full SETTLE_CYCLES+1 edges.
- R6: `trx_enable_o` is high only in the up state. When `speed_10_i`=0, `link_status_o` and `link_led_o` both equal `trx_enable_o`.
- R7: When `speed_10_i`=1, `link_status_o` and `link_led_o` equal the value of `link_10_i` sampled at the previous rising edge.
- R8: While `rst_ni` is low, and on the first cycle after it rises, all three outputs are low.
- R9: If `data_valid_i` falls while the machine is ready and waiting for auto-negotiation, the machine returns to Down. The full settling time is required again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_valid_i | input | 1 | Valid 100 Mb/s line signal seen by the receive signal processor |
| an_enable_i | input | 1 | 1 = auto-negotiation in use; 0 = bypass the wait for it |
| an_done_i | input | 1 | Go-ahead from auto-negotiation |
| speed_10_i | input | 1 | 1 = 10BASE-T mode; 0 = 100 Mb/s mode |
| link_10_i | input | 1 | Link flag from the 10BASE-T receiver |
| link_status_o | output | 1 | Reported link status |
| link_led_o | output | 1 | Link LED drive |
| trx_enable_o | output | 1 | Transmit/receive enable |

## Verification
The assertions assume that `data_valid_i` and the mode inputs are synchronous to `clk_i` and change only between edges. They also assume that the settling check can count consecutive high samples of `data_valid_i` from reset onward. The directed stimulus changes every input one time unit after a rising edge. It never toggles `data_valid_i` twice within a cycle. Mode inputs change only while the data-valid flag is low, so the link-source check always compares against a sample the design has also seen.

// File: rtl/link_mon_pkg.sv
package link_mon_pkg;
  typedef enum logic [1:0] {
    LM_DOWN   = 2'd0,
    LM_SETTLE = 2'd1,
    LM_READY  = 2'd2,
    LM_UP     = 2'd3
  } lm_state_e;
endpackage

// File: rtl/link_settle_timer.sv
module link_settle_timer #(
  parameter int unsigned CYCLES = 8250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  // any gap in run_i restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (done_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/link_fsm.sv
module link_fsm
  import link_mon_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      data_valid_i,
  input  logic      an_enable_i,
  input  logic      an_done_i,
  input  logic      settle_done_i,
  output logic      settle_run_o,
  output logic      up_o
);
  lm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!data_valid_i) begin
      state_d = LM_DOWN;
    end else begin
      unique case (state_q)
        LM_DOWN:   state_d = LM_SETTLE;
        LM_SETTLE: if (settle_done_i) state_d = an_enable_i ? LM_READY : LM_UP;
        LM_READY:  if (!an_enable_i || an_done_i) state_d = LM_UP;
        LM_UP:     state_d = LM_UP;
        default:   state_d = LM_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LM_DOWN;
    else         state_q <= state_d;
  end

  assign settle_run_o = (state_q == LM_SETTLE) && data_valid_i;
  // loss of valid cuts the link without waiting for an edge
  assign up_o         = (state_q == LM_UP) && data_valid_i;
endmodule

// File: rtl/link_src_mux.sv
module link_src_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic speed_10_i,
  input  logic link_10_i,
  input  logic link_100_i,
  output logic link_o
);
  logic link_10_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_10_q <= 1'b0;
    else         link_10_q <= link_10_i;
  end

  assign link_o = speed_10_i ? link_10_q : link_100_i;
endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
  parameter int unsigned SETTLE_CYCLES = 8250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_valid_i,
  input  logic an_enable_i,
  input  logic an_done_i,
  input  logic speed_10_i,
  input  logic link_10_i,
  output logic link_status_o,
  output logic link_led_o,
  output logic trx_enable_o
);
  logic settle_run, settle_done, link_100, link_sel;

  link_settle_timer #(.CYCLES(SETTLE_CYCLES)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (settle_run),
    .done_o (settle_done)
  );

  link_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .data_valid_i  (data_valid_i),
    .an_enable_i   (an_enable_i),
    .an_done_i     (an_done_i),
    .settle_done_i (settle_done),
    .settle_run_o  (settle_run),
    .up_o          (link_100)
  );

  link_src_mux i_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .speed_10_i (speed_10_i),
    .link_10_i  (link_10_i),
    .link_100_i (link_100),
    .link_o     (link_sel)
  );

  assign link_status_o = link_sel;
  assign link_led_o    = link_sel;
  assign trx_enable_o  = link_100;
endmodule

// File: rtl/link_integrity_mon_chk.sv
module link_integrity_mon_chk #(
  parameter int unsigned SETTLE_CYCLES = 8250
) (
  input logic clk_i,
  input logic rst_ni,
  input logic data_valid_i,
  input logic an_enable_i,
  input logic an_done_i,
  input logic speed_10_i,
  input logic link_10_i,
  input logic link_status_o,
  input logic link_led_o,
  input logic trx_enable_o
);
  localparam int unsigned RW = $clog2(SETTLE_CYCLES + 3);
  localparam logic [RW-1:0] RMAX = RW'(SETTLE_CYCLES + 1);

  logic [RW-1:0] run_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      if (!data_valid_i)     run_q <= '0;
      else if (run_q < RMAX) run_q <= run_q + 1'b1;
    end
  end

  AST_SETTLE_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trx_enable_o) |-> (run_q == RMAX)); // R1

  AST_AN_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trx_enable_o) |-> (!$past(an_enable_i) || $past(an_done_i))); // R2

  AST_DROP_ON_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_i |-> !trx_enable_o); // R4

  AST_100_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !speed_10_i |-> (link_status_o == trx_enable_o)); // R6

  AST_LED_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_led_o == link_status_o); // R6

  AST_10_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_10_i && seen_q) |-> (link_status_o == $past(link_10_i))); // R7

  AST_FIRST_CYCLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !trx_enable_o); // R8
endmodule

bind link_integrity_mon link_integrity_mon_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .data_valid_i  (data_valid_i),
  .an_enable_i   (an_enable_i),
  .an_done_i     (an_done_i),
  .speed_10_i    (speed_10_i),
  .link_10_i     (link_10_i),
  .link_status_o (link_status_o),
  .link_led_o    (link_led_o),
  .trx_enable_o  (trx_enable_o)
);

// File: tb/test_link_integrity_mon.sv
`timescale 1ns/1ps
module test_link_integrity_mon;
  localparam int unsigned N = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic data_valid_i = 1'b0, an_enable_i = 1'b0, an_done_i = 1'b0;
  logic speed_10_i = 1'b0, link_10_i = 1'b0;
  logic link_status_o, link_led_o, trx_enable_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  link_integrity_mon #(.SETTLE_CYCLES(N)) i_link_integrity_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_valid_i(data_valid_i),
    .an_enable_i(an_enable_i), .an_done_i(an_done_i), .speed_10_i(speed_10_i),
    .link_10_i(link_10_i), .link_status_o(link_status_o),
    .link_led_o(link_led_o), .trx_enable_o(trx_enable_o)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic go_down();
    data_valid_i = 1'b0; an_done_i = 1'b0;
    tick(2);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; speed_10_i = 1'b1; link_10_i = 1'b1; data_valid_i = 1'b1;
    tick(3);
    check("R8", "status in reset", link_status_o, 1'b0);
    check("R8", "led in reset", link_led_o, 1'b0);
    check("R8", "trx in reset", trx_enable_o, 1'b0);
    speed_10_i = 1'b0; link_10_i = 1'b0; data_valid_i = 1'b0;
    rst_ni = 1'b1;
    tick(1);
    check("R8", "trx after reset", trx_enable_o, 1'b0);
    check("R8", "status after reset", link_status_o, 1'b0);
  endtask

  task automatic t_bypass();
    an_enable_i = 1'b0; an_done_i = 1'b0; data_valid_i = 1'b1;
    tick(N);
    check("R1", "link before settling", link_status_o, 1'b0);
    tick(1);
    check("R3", "link after settling, no autoneg", link_status_o, 1'b1);
    check("R6", "trx in up", trx_enable_o, 1'b1);
    check("R6", "led in up", link_led_o, 1'b1);
    go_down();
  endtask

  task automatic t_an_wait();
    an_enable_i = 1'b1; an_done_i = 1'b0; data_valid_i = 1'b1;
    tick(N + 1);
    check("R2", "link at ready without go-ahead", link_status_o, 1'b0);
    tick(5);
    check("R2", "still waiting for go-ahead", trx_enable_o, 1'b0);
    an_done_i = 1'b1;
    #1;
    check("R2", "no rise before edge", trx_enable_o, 1'b0);
    tick(1);
    check("R2", "link after go-ahead", link_status_o, 1'b1);
    go_down();
    an_enable_i = 1'b0;
  endtask

  task automatic t_loss_up();
    data_valid_i = 1'b1;
    tick(N + 1);
    check("R3", "up before loss", trx_enable_o, 1'b1);
    data_valid_i = 1'b0;
    #1;
    check("R4", "trx drops at once", trx_enable_o, 1'b0);
    check("R4", "status drops at once", link_status_o, 1'b0);
    tick(1);
    data_valid_i = 1'b1;
    tick(N);
    check("R4", "no relink before full settle", link_status_o, 1'b0);
    tick(1);
    check("R4", "relink after full settle", link_status_o, 1'b1);
    go_down();
  endtask

  task automatic t_restart();
    data_valid_i = 1'b1;
    tick(N - 2);
    data_valid_i = 1'b0;
    tick(1);
    data_valid_i = 1'b1;
    tick(N);
    check("R5", "count restarted after gap", link_status_o, 1'b0);
    tick(1);
    check("R5", "link after fresh window", link_status_o, 1'b1);
    go_down();
  endtask

  task automatic t_ready_loss();
    an_enable_i = 1'b1; an_done_i = 1'b0; data_valid_i = 1'b1;
    tick(N + 1);
    data_valid_i = 1'b0;
    tick(1);
    data_valid_i = 1'b1; an_done_i = 1'b1;
    tick(N + 1);
    check("R9", "ready left on loss", link_status_o, 1'b0);
    tick(1);
    check("R9", "link after resettle", link_status_o, 1'b1);
    go_down();
    an_enable_i = 1'b0;
  endtask

  task automatic t_ten_mode();
    speed_10_i = 1'b1; link_10_i = 1'b1;
    #1;
    check("R7", "10M link before sampling", link_status_o, 1'b0);
    tick(1);
    check("R7", "10M link sampled", link_status_o, 1'b1);
    check("R7", "10M led sampled", link_led_o, 1'b1);
    check("R6", "trx off outside up in 10M", trx_enable_o, 1'b0);
    link_10_i = 1'b0;
    #1;
    check("R7", "10M link held until edge", link_status_o, 1'b1);
    tick(1);
    check("R7", "10M link cleared", link_status_o, 1'b0);
    speed_10_i = 1'b0;
    tick(1);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_an_wait();
    t_loss_up();
    t_restart();
    t_ready_loss();
    t_ten_mode();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule